// File: doc/BRIEF.md
# Dual-Granularity Set-Associative Data Cache

This block is a four-way set-associative data cache placed between a processor load/store port and a word-addressed main-memory port. Every request carries a mode flag. On a scalar load miss the cache brings in the whole aligned eight-word line. On a vector load miss it brings in only the one addressed word, so strided and gather patterns move no extra words. Each line holds one tag and a valid bit for each of its eight words. A load hits only when the tag matches and the addressed word is valid.

Stores are write-through with write-allocate. Each store updates the cache word and is also sent to memory. A store miss claims a line and marks only the written word valid, without fetching the rest of the line. Ways within a set are replaced in least-recently-used order. Coherence is left to software: a one-cycle flush pulse invalidates every word in the cache. Only one request is in flight at a time.

Capacity is set by a parameter. With 32768 words, lines 8192 words apart share a set. The default is kept smaller so that elaboration stays light.

Top module: `dual_gran_dcache`

## Requirements
- R1: After reset, `req_ready_o` is high, and `rsp_valid_o` and `mem_req_valid_o` are low. The first load to any address misses.
- R2: A scalar load miss (`req_vector_i`=0) issues eight memory reads. They cover the aligned line (address with its low three bits replaced by 0..7) in ascending order. The response carries the requested word, and all eight words then hit.
- R3: A vector load miss (`req_vector_i`=1) issues exactly one memory read, at the addressed word. A neighbouring word in the same line still misses afterwards and again costs exactly one read.
- R4: A fill into a line whose tag already matches keeps that line's other valid words. A vector fill adds one word. A scalar miss on a partly valid line re-reads all eight words.
- R5: A load hit raises `rsp_valid_o` with the cached word in the cycle after acceptance. It issues no memory request and leaves `req_ready_o` high.
- R6: A store issues exactly one memory write (`mem_req_write_o`=1) with the request's address and data. `req_ready_o` stays low until the memory accepts that write.
- R7: After a store, a load of that word returns the stored value with no memory read, whether the store hit or allocated a line.
- R8: Address bits [3 +: log2(sets)] pick the set, so words CAP_WORDS/4 apart share a set. Empty ways are filled first. A fifth line in a full set evicts the least recently used one, and recently touched lines remain.
- R9: While `flush_i` is high, `req_ready_o` is low. After the pulse, every previously cached word misses.
- R10: From the acceptance of a load miss until its last fill word returns, `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate whole cache |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_vector_i | input | 1 | 1 = vector access, 0 = scalar |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Load data valid (one cycle) |
| rsp_rdata_o | output | DATA_W | Load data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Memory word address |
| mem_req_wdata_o | output | DATA_W | Memory write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | DATA_W | Read data |

## Verification
The bench builds the cache with a 12-bit address and 128 words of capacity. That gives four sets of four ways, with set-sharing addresses only 32 words apart. Five aliasing lines therefore fill one set and force LRU eviction in a handful of accesses, while lines in other sets stay resident for hit checks. The memory model answers reads one cycle after acceptance, and it can hold off its ready to expose the store handshake.

// File: rtl/dual_gran_dcache_pkg.sv
package dual_gran_dcache_pkg;
  localparam int unsigned WAYS       = 4;
  localparam int unsigned WAY_W      = 2;
  localparam int unsigned LINE_WORDS = 8;
  localparam int unsigned OFF_W      = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } dc_state_e;
endpackage

// File: rtl/dgc_tag_store.sv
module dgc_tag_store
  import dual_gran_dcache_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 23
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  flush_i,
  input  logic [IDX_W-1:0]                      idx_i,
  input  logic                                  upd_i,
  input  logic [WAY_W-1:0]                      upd_way_i,
  input  logic                                  clr_i,
  input  logic [TAG_W-1:0]                      tag_i,
  input  logic                                  set_i,
  input  logic [OFF_W-1:0]                      word_i,
  output logic [WAYS-1:0][TAG_W-1:0]            tags_o,
  output logic [WAYS-1:0][LINE_WORDS-1:0]       vld_o
);
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]      tag_q [SETS];
      logic [LINE_WORDS-1:0] vld_q [SETS];
      logic [LINE_WORDS-1:0] vld_d;
      logic                  way_en;

      assign way_en = upd_i && (upd_way_i == WAY_W'(w));

      always_comb begin
        vld_d = clr_i ? '0 : vld_q[idx_i];
        if (set_i) vld_d[word_i] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (flush_i) begin
          for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (way_en) begin
          vld_q[idx_i] <= vld_d;
        end
      end

      always_ff @(posedge clk) begin
        if (way_en && clr_i) tag_q[idx_i] <= tag_i;
      end

      assign tags_o[w] = tag_q[idx_i];
      assign vld_o[w]  = vld_q[idx_i];
    end
  endgenerate
endmodule

// File: rtl/dgc_data_store.sv
module dgc_data_store
  import dual_gran_dcache_pkg::*;
#(
  parameter int unsigned SETS   = 64,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 64
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [OFF_W-1:0]             word_i,
  input  logic                         we_i,
  input  logic [WAY_W-1:0]             we_way_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [WAYS-1:0][DATA_W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = SETS * LINE_WORDS;

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      logic [DATA_W-1:0] mem_q [DEPTH];
      always_ff @(posedge clk) begin
        if (we_i && (we_way_i == WAY_W'(w))) mem_q[{idx_i, word_i}] <= wdata_i;
      end
      assign rdata_o[w] = mem_q[{idx_i, word_i}];
    end
  endgenerate
endmodule

// File: rtl/dgc_lru.sv
module dgc_lru
  import dual_gran_dcache_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              touch_i,
  input  logic [WAY_W-1:0]  touch_way_i,
  input  logic [WAYS-1:0]   empty_i,
  output logic [WAY_W-1:0]  victim_o
);
  logic [WAYS-1:0][1:0] age_q [SETS];
  logic [WAYS-1:0][1:0] age_cur, age_d;

  assign age_cur = age_q[idx_i];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way_i)            age_d[w] = 2'd0;
      else if (age_cur[w] < age_cur[touch_way_i]) age_d[w] = age_cur[w] + 2'd1;
      else                                     age_d[w] = age_cur[w];
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (empty_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_cur[w] == 2'd3) victim_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= 2'(w);
    end else if (touch_i) begin
      age_q[idx_i] <= age_d;
    end
  end
endmodule

// File: rtl/dual_gran_dcache.sv
module dual_gran_dcache
  import dual_gran_dcache_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned CAP_WORDS = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_vector_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  localparam int unsigned SETS  = CAP_WORDS / (WAYS * LINE_WORDS);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;

  dc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] r_addr_q;
  logic [DATA_W-1:0] r_wdata_q;
  logic              r_vec_q;
  logic [WAY_W-1:0]  r_way_q;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  logic [ADDR_W-1:0] lk_addr;
  logic [OFF_W-1:0]  lk_word, fill_word;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;

  logic [WAYS-1:0][TAG_W-1:0]      tags_rd;
  logic [WAYS-1:0][LINE_WORDS-1:0] vld_rd;
  logic [WAYS-1:0][DATA_W-1:0]     data_rd;
  logic [WAYS-1:0]                 tmatch, whit, empty;
  logic                            hit, line_hit, accept, fill_beat, last_beat;
  logic [WAY_W-1:0]                match_way, victim, sel_way;

  logic              upd, clr, setv, dwe;
  logic [WAY_W-1:0]  upd_way;
  logic [OFF_W-1:0]  upd_word;
  logic [DATA_W-1:0] dwdata;

  // lookup
  assign lk_addr = (state_q == ST_IDLE) ? req_addr_i : r_addr_q;
  assign lk_word = lk_addr[OFF_W-1:0];
  assign lk_idx  = lk_addr[OFF_W +: IDX_W];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign tmatch[w] = (tags_rd[w] == lk_tag) && (|vld_rd[w]);
      assign whit[w]   = tmatch[w] && vld_rd[w][lk_word];
      assign empty[w]  = ~|vld_rd[w];
    end
  endgenerate

  always_comb begin
    match_way = '0;
    for (int i = 0; i < WAYS; i++) if (tmatch[i]) match_way = WAY_W'(i);
  end

  assign hit       = |whit;
  assign line_hit  = |tmatch;
  assign sel_way   = line_hit ? match_way : victim;
  assign req_ready_o = (state_q == ST_IDLE) && !flush_i;
  assign accept    = req_valid_i && req_ready_o;
  assign fill_word = r_vec_q ? r_addr_q[OFF_W-1:0] : cnt_q;
  assign fill_beat = (state_q == ST_RD_WAIT) && mem_rsp_valid_i;
  assign last_beat = r_vec_q || (cnt_q == OFF_W'(LINE_WORDS - 1));

  // array update controls
  always_comb begin
    upd      = 1'b0;
    clr      = 1'b0;
    setv     = 1'b0;
    dwe      = 1'b0;
    upd_way  = sel_way;
    upd_word = lk_word;
    dwdata   = req_wdata_i;
    if (accept && req_write_i) begin
      upd  = 1'b1;
      clr  = !line_hit;
      setv = 1'b1;
      dwe  = 1'b1;
    end else if (accept && !hit) begin
      upd = !line_hit;
      clr = !line_hit;
    end else if (fill_beat) begin
      upd      = 1'b1;
      setv     = 1'b1;
      dwe      = 1'b1;
      upd_way  = r_way_q;
      upd_word = fill_word;
      dwdata   = mem_rsp_rdata_i;
    end
  end

  // next state
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    rsp_valid_d = 1'b0;
    rsp_data_d  = mem_rsp_rdata_i;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept && req_write_i) begin
          state_d = ST_WR_REQ;
        end else if (accept && hit) begin
          rsp_valid_d = 1'b1;
          rsp_data_d  = data_rd[match_way];
        end else if (accept) begin
          state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ:  if (mem_req_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (mem_rsp_valid_i) begin
          rsp_valid_d = (fill_word == r_addr_q[OFF_W-1:0]);
          if (last_beat) state_d = ST_IDLE;
          else begin
            state_d = ST_RD_REQ;
            cnt_d   = cnt_q + OFF_W'(1);
          end
        end
      end
      ST_WR_REQ:  if (mem_req_ready_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      r_addr_q  <= req_addr_i;
      r_wdata_q <= req_wdata_i;
      r_vec_q   <= req_vector_i;
      r_way_q   <= sel_way;
    end
    if (rsp_valid_d) rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_rdata_o     = rsp_data_q;
  assign mem_req_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write_o = (state_q == ST_WR_REQ);
  assign mem_req_addr_o  = (state_q == ST_WR_REQ) ? r_addr_q
                         : {r_addr_q[ADDR_W-1:OFF_W], fill_word};
  assign mem_req_wdata_o = r_wdata_q;

  dgc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .idx_i(lk_idx),
    .upd_i(upd), .upd_way_i(upd_way), .clr_i(clr), .tag_i(lk_tag),
    .set_i(setv), .word_i(upd_word), .tags_o(tags_rd), .vld_o(vld_rd)
  );

  dgc_data_store #(.SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .idx_i(lk_idx), .word_i(dwe ? upd_word : lk_word), .we_i(dwe),
    .we_way_i(upd_way), .wdata_i(dwdata), .rdata_o(data_rd)
  );

  dgc_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .idx_i(lk_idx), .touch_i(accept),
    .touch_way_i(sel_way), .empty_i(empty), .victim_o(victim)
  );
endmodule

// File: rtl/dual_gran_dcache_sva.sv
module dual_gran_dcache_sva #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic              rsp_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_write_o,
  input logic [ADDR_W-1:0] mem_req_addr_o
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> !req_ready_o); // R10

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !req_ready_o); // R9

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o))); // R6

  AST_STORE_WRITES_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_write_i) |=> (mem_req_valid_o && mem_req_write_o)); // R6

  AST_LOAD_HIT_OR_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !req_write_i) |=>
      (rsp_valid_o || (mem_req_valid_o && !mem_req_write_o))); // R5
endmodule

bind dual_gran_dcache dual_gran_dcache_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_write_i(req_write_i), .rsp_valid_o(rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o)
);

// File: tb/dual_gran_dcache_tb.sv
`timescale 1ns/1ps
module dual_gran_dcache_tb;
  localparam int AW = 12;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic          req_valid, req_write, req_vector;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          mem_req_valid_o, mem_req_write_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic          mem_rdy;
  logic          mrsp_v;
  logic [DW-1:0] mrsp_d;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_gran_dcache #(.ADDR_W(AW), .DATA_W(DW), .CAP_WORDS(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_vector_i(req_vector), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_rdy),
    .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mrsp_v),
    .mem_rsp_rdata_i(mrsp_d)
  );

  function automatic logic [DW-1:0] iw(input logic [AW-1:0] a);
    return {32'hC0DE_0000 | 32'(a), 32'h5A5A_0000 | 32'(a)};
  endfunction

  // memory model: reads answered one cycle after acceptance
  logic [DW-1:0] bmem [1 << AW];
  logic [AW-1:0] rd_log [256];
  int            rd_cnt, wr_cnt;
  logic          pend;
  logic [AW-1:0] pend_a;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) bmem[i] <= iw(AW'(i));
      rd_cnt <= 0; wr_cnt <= 0; pend <= 1'b0; mrsp_v <= 1'b0; mrsp_d <= '0;
    end else begin
      mrsp_v <= 1'b0;
      if (pend) begin
        mrsp_v <= 1'b1;
        mrsp_d <= bmem[pend_a];
        pend   <= 1'b0;
      end
      if (mem_req_valid_o && mem_rdy) begin
        if (mem_req_write_o) begin
          bmem[mem_req_addr_o] <= mem_req_wdata_o;
          wr_cnt <= wr_cnt + 1;
        end else begin
          pend   <= 1'b1;
          pend_a <= mem_req_addr_o;
          rd_log[rd_cnt[7:0]] <= mem_req_addr_o;
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic check_eq(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                          input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a, input bit vec, input logic [DW-1:0] exp_d,
                         input int exp_reads, input string req);
    int r0, n;
    logic [DW-1:0] got;
    bit ready_low;
    r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vector = vec; req_addr = a;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ready_low = !req_ready_o;
    n = 0;
    while (!rsp_valid_o && n < 300) begin @(negedge clk); n++; end
    got = rsp_rdata_o;
    while (!req_ready_o) @(negedge clk);
    check_eq(got, exp_d, req, "load data");
    check_eq(DW'(rd_cnt - r0), DW'(exp_reads), req, "memory reads");
    if (exp_reads == 0) check_eq(DW'(n), 0, "R5", "hit response delay");
    else                check_eq(DW'(ready_low), 1, "R10", "ready low during fill");
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit stall);
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    mem_rdy = !stall;
    req_valid = 1'b1; req_write = 1'b1; req_vector = 1'b0; req_addr = a; req_wdata = d;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (stall) begin
      for (int k = 0; k < 3; k++) begin
        check_eq(DW'(req_ready_o), 0, "R6", "ready low while write stalled");
        @(negedge clk);
      end
      mem_rdy = 1'b1;
    end
    while (!req_ready_o) @(negedge clk);
    check_eq(DW'(wr_cnt - w0), 1, "R6", "memory writes");
    check_eq(bmem[a], d, "R6", "memory written data");
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    check_eq(DW'(req_ready_o), 0, "R9", "ready during flush");
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check_eq(DW'(req_ready_o), 1, "R1", "ready after reset");
    check_eq(DW'(rsp_valid_o), 0, "R1", "rsp after reset");
    check_eq(DW'(mem_req_valid_o), 0, "R1", "mem req after reset");
  endtask

  task automatic t_scalar();
    int r0;
    r0 = rd_cnt;
    do_load(12'h105, 1'b0, iw(12'h105), 8, "R1");
    for (int k = 0; k < 8; k++)
      check_eq(DW'(rd_log[8'(r0 + k)]), DW'(12'h100 + k), "R2", "line read order");
    do_load(12'h102, 1'b0, iw(12'h102), 0, "R2");
    do_load(12'h107, 1'b1, iw(12'h107), 0, "R5");
  endtask

  task automatic t_vector();
    do_load(12'h20A, 1'b1, iw(12'h20A), 1, "R3");
    check_eq(DW'(rd_log[8'(rd_cnt - 1)]), DW'(12'h20A), "R3", "vector read address");
    do_load(12'h20B, 1'b1, iw(12'h20B), 1, "R3");
    do_load(12'h20A, 1'b1, iw(12'h20A), 0, "R4");
    do_load(12'h20C, 1'b0, iw(12'h20C), 8, "R4");
    do_load(12'h20F, 1'b1, iw(12'h20F), 0, "R4");
  endtask

  task automatic t_store();
    do_store(12'h300, 64'hDEAD_BEEF_0000_0300, 1'b1);
    do_load(12'h300, 1'b1, 64'hDEAD_BEEF_0000_0300, 0, "R7");
    do_store(12'h105, 64'h1234_5678_9ABC_0105, 1'b0);
    do_load(12'h105, 1'b0, 64'h1234_5678_9ABC_0105, 0, "R7");
    do_load(12'h104, 1'b0, iw(12'h104), 0, "R7");
  endtask

  task automatic t_flush();
    do_flush();
    do_load(12'h102, 1'b0, iw(12'h102), 8, "R9");
    do_load(12'h300, 1'b1, 64'hDEAD_BEEF_0000_0300, 1, "R9");
  endtask

  task automatic t_lru();
    do_flush();
    // four sets of 4 ways x 8 words: stride 32 words shares set 2
    do_load(12'h010, 1'b1, iw(12'h010), 1, "R8");
    do_load(12'h030, 1'b1, iw(12'h030), 1, "R8");
    do_load(12'h050, 1'b1, iw(12'h050), 1, "R8");
    do_load(12'h070, 1'b1, iw(12'h070), 1, "R8");
    do_load(12'h010, 1'b1, iw(12'h010), 0, "R8");
    do_load(12'h090, 1'b1, iw(12'h090), 1, "R8");
    do_load(12'h010, 1'b1, iw(12'h010), 0, "R8");
    do_load(12'h050, 1'b1, iw(12'h050), 0, "R8");
    do_load(12'h070, 1'b1, iw(12'h070), 0, "R8");
    do_load(12'h030, 1'b1, iw(12'h030), 1, "R8");
    do_load(12'h090, 1'b1, iw(12'h090), 1, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_vector = 1'b0; req_addr = '0; req_wdata = '0; mem_rdy = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scalar();
    t_vector();
    t_store();
    t_flush();
    t_lru();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule